// File: doc/BRIEF.md
# Nested Prioritised Interrupt Controller

This block collects 112 level-sensitive request lines, keeps a sticky pending flag for each one, and picks the most urgent enabled request. Each line has an 8-bit priority byte, but only its upper 6 bits are stored and compared, which gives 64 levels. A smaller value means a more urgent request, and a tie goes to the lower line number. A two-stage pipeline performs the selection and presents the winner's line number and 6-bit level to the core.

The controller keeps a stack of the levels that are in service. It raises `irq_req` only when the winner is strictly more urgent than the level at the top of that stack. The core accepts with `core_ack` and reports the end of a handler with `core_done`. If, when a handler ends, a pending request beats the level that would otherwise be restored, the controller chains straight into it and flags this on `tail_take`. Software programs enables, priorities and pending flags through a small word-wide register port. Bits [7:5] of the address select a region and bits [4:0] select a word within it.

Top module: `nested_irq_ctrl`

## Requirements
- R1: After a synchronous active-low reset, all enables, pending flags and priorities read zero, and `irq_req`, `tail_take` and `run_valid` are low.
- R2: A high request line sets its pending flag on the next edge, and the flag stays set after the line falls. The set region (1) sets flags where the written word has ones, and the clear region (2) clears them. Writing zeros has no effect. Both regions read back the pending flags. Line n sits in word n/32, bit n%32.
- R3: In the priority region (3), word k holds lines 4k..4k+3, and line 4k+j uses byte j. Bits [1:0] of every byte read back as zero and take no part in comparison.
- R4: The presented winner is the enabled pending line with the lowest 6-bit level, and a tie goes to the lowest line number. A pending line that is not enabled (enable region 0) is never presented.
- R5: The winner reflects a pending change that is latched at edge e from edge e+2 onward. After any register write or any acceptance at edge e, `irq_req` and `tail_take` stay low until edge e+2.
- R6: `irq_req` is high only when a winner exists and either nothing is in service or the winner's level is strictly lower than `run_prio`.
- R7: `core_ack` while `irq_req` is high pushes the winner's level, so `run_prio` takes that level. The line's pending flag clears, and a later request on the same line can set it again while that line is in service.
- R8: `core_done` without a chain pops the stack, so `run_prio` returns to the previous level, or `run_valid` falls once the stack is empty.
- R9: `core_done` raises `tail_take` in the same cycle when a winner is strictly more urgent than the level beneath the top. With a single level in service, any winner qualifies. On a chain, the stack depth is unchanged, `run_prio` becomes the winner's level, and the winner's pending flag clears.
- R10: When `DEPTH` (default 8) levels are in service, `irq_req` stays low, although a chain on `core_done` is still possible.
- R11: `core_ack` while `irq_req` is low, and `core_done` while nothing is in service, change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_line | input | 112 | Level request lines |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 8 | Region [7:5], word index [4:0] |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` (combinational) |
| core_ack | input | 1 | Core accepts the presented request |
| core_done | input | 1 | Core finishes the current handler |
| irq_req | output | 1 | Winner may preempt now |
| irq_id | output | 7 | Winner line number |
| irq_prio | output | 6 | Winner 6-bit level |
| tail_take | output | 1 | Handler exit chains into the winner this cycle |
| run_valid | output | 1 | At least one level in service |
| run_prio | output | 6 | Level at the top of the service stack |

## Verification
Every result has a fixed due cycle. A line or register change latched at one edge appears at the winner outputs two edges later, with `irq_req` held low during those two edges. Stack updates from an acceptance or a handler exit show on `run_prio` right after the edge that takes them. `tail_take` is combinational, so it is visible in the same cycle as `core_done`. The bench drives inputs on falling edges and samples shortly after them. Latency checks sample on each of the three falling edges after the stimulus edge and expect low, low, then high. All other checks wait three falling edges, so they see settled values.

// File: rtl/nic_pkg.sv
// Shared definitions for the nested interrupt controller.
// Assumes the register address carries a 3-bit region code in its top bits.
package nic_pkg;
    localparam int REGION_W = 3;

    typedef enum logic [REGION_W-1:0] {
        RG_ENABLE  = 3'd0,
        RG_SETPEND = 3'd1,
        RG_CLRPEND = 3'd2,
        RG_PRIO    = 3'd3
    } region_e;
endpackage

// File: rtl/nic_regs.sv
// Register file: enables, sticky pending flags and 6-bit levels per line.
// Assumes at most 2**(ADDR_W-3) words per region; reads are combinational.
module nic_regs
    import nic_pkg::*;
#(
    parameter int NUM_IRQ = 112,
    parameter int LVL_W   = 6,
    parameter int PRIO_W  = 8,
    parameter int DATA_W  = 32,
    parameter int ADDR_W  = 8,
    parameter int ID_W    = 7
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NUM_IRQ-1:0]       irq_line,
    input  logic                     reg_we,
    input  logic [ADDR_W-1:0]        reg_addr,
    input  logic [DATA_W-1:0]        reg_wdata,
    output logic [DATA_W-1:0]        reg_rdata,
    input  logic                     acc_valid,
    input  logic [ID_W-1:0]          acc_id,
    output logic [NUM_IRQ-1:0]       req_vec,
    output logic [NUM_IRQ*LVL_W-1:0] lvl_flat
);
    localparam int IDX_W  = ADDR_W - REGION_W;
    localparam int FIELDS = DATA_W / PRIO_W;
    localparam int SKIP   = PRIO_W - LVL_W;

    logic [NUM_IRQ-1:0] pend_q, en_q, pend_d, en_d;
    logic [NUM_IRQ-1:0] set_m, clr_m, acc_m;
    logic [LVL_W-1:0]   lvl_q [NUM_IRQ];
    logic [LVL_W-1:0]   lvl_d [NUM_IRQ];
    region_e            region;
    logic [IDX_W-1:0]   idx;

    assign region = region_e'(reg_addr[ADDR_W-1 -: REGION_W]);
    assign idx    = reg_addr[IDX_W-1:0];

    // Decode writes and acceptance into per-line next-state values.
    always_comb begin
        set_m = '0;
        clr_m = '0;
        acc_m = '0;
        en_d  = en_q;
        for (int i = 0; i < NUM_IRQ; i++) begin
            lvl_d[i] = lvl_q[i];
            acc_m[i] = acc_valid && (acc_id == ID_W'(i));
            if (reg_we && idx == IDX_W'(i / DATA_W)) begin
                if (region == RG_SETPEND) set_m[i] = reg_wdata[i % DATA_W];
                if (region == RG_CLRPEND) clr_m[i] = reg_wdata[i % DATA_W];
                if (region == RG_ENABLE)  en_d[i]  = reg_wdata[i % DATA_W];
            end
            if (reg_we && region == RG_PRIO && idx == IDX_W'(i / FIELDS))
                lvl_d[i] = reg_wdata[(i % FIELDS) * PRIO_W + SKIP +: LVL_W];
        end
        pend_d = ((pend_q | set_m) & ~clr_m & ~acc_m) | irq_line;
    end

    // Hold enables, pending flags and levels.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= '0;
            en_q   <= '0;
            for (int i = 0; i < NUM_IRQ; i++) lvl_q[i] <= '0;
        end else begin
            pend_q <= pend_d;
            en_q   <= en_d;
            for (int i = 0; i < NUM_IRQ; i++) lvl_q[i] <= lvl_d[i];
        end
    end

    // Read mux: place each line's state in the addressed word.
    always_comb begin
        reg_rdata = '0;
        for (int i = 0; i < NUM_IRQ; i++) begin
            if (idx == IDX_W'(i / DATA_W)) begin
                if (region == RG_ENABLE) reg_rdata[i % DATA_W] = en_q[i];
                if (region == RG_SETPEND || region == RG_CLRPEND)
                    reg_rdata[i % DATA_W] = pend_q[i];
            end
            if (region == RG_PRIO && idx == IDX_W'(i / FIELDS))
                reg_rdata[(i % FIELDS) * PRIO_W + SKIP +: LVL_W] = lvl_q[i];
        end
    end

    // Present the candidate vector and the flattened levels to the resolver.
    always_comb begin
        req_vec = pend_q & en_q;
        for (int i = 0; i < NUM_IRQ; i++) lvl_flat[i*LVL_W +: LVL_W] = lvl_q[i];
    end

    a_r2_line_sets_pending: assert property (@(posedge clk) disable iff (!rst_n)
        (|irq_line) |=> ((pend_q & $past(irq_line)) == $past(irq_line)));

    a_r7_accept_clears: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid |=> (!pend_q[$past(acc_id)] || $past(irq_line[acc_id]) ||
                       $past(set_m[acc_id])));
endmodule

// File: rtl/nic_resolver.sv
// Two-stage winner search: lowest level wins, ties go to the lower line.
// Assumes GROUP is a power of two; the output lags the inputs by two edges.
module nic_resolver #(
    parameter int NUM_IRQ = 112,
    parameter int LVL_W   = 6,
    parameter int GROUP   = 16,
    parameter int ID_W    = 7
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NUM_IRQ-1:0]       req_vec,
    input  logic [NUM_IRQ*LVL_W-1:0] lvl_flat,
    output logic                     win_valid,
    output logic [ID_W-1:0]          win_id,
    output logic [LVL_W-1:0]         win_lvl
);
    localparam int NGRP  = (NUM_IRQ + GROUP - 1) / GROUP;
    localparam int NPAD  = NGRP * GROUP;
    localparam int LID_W = $clog2(GROUP);

    logic [NPAD-1:0]       req_pad;
    logic [NPAD*LVL_W-1:0] lvl_pad;
    logic                  s1_v [NGRP];
    logic [LID_W-1:0]      s1_i [NGRP];
    logic [LVL_W-1:0]      s1_l [NGRP];

    assign req_pad = NPAD'(req_vec);
    assign lvl_pad = (NPAD*LVL_W)'(lvl_flat);

    for (genvar g = 0; g < NGRP; g++) begin : g_grp
        logic             bv;
        logic [LID_W-1:0] bi;
        logic [LVL_W-1:0] bl;

        // Scan one group in ascending order; strict compare keeps the lower index.
        always_comb begin
            bv = 1'b0;
            bi = '0;
            bl = '1;
            for (int k = 0; k < GROUP; k++) begin
                if (req_pad[g*GROUP+k] &&
                    (!bv || lvl_pad[(g*GROUP+k)*LVL_W +: LVL_W] < bl)) begin
                    bv = 1'b1;
                    bi = LID_W'(k);
                    bl = lvl_pad[(g*GROUP+k)*LVL_W +: LVL_W];
                end
            end
        end

        // Stage-one register for this group's winner.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                s1_v[g] <= 1'b0;
                s1_i[g] <= '0;
                s1_l[g] <= '0;
            end else begin
                s1_v[g] <= bv;
                s1_i[g] <= bi;
                s1_l[g] <= bl;
            end
        end
    end

    logic             fv;
    logic [ID_W-1:0]  fi;
    logic [LVL_W-1:0] fl;

    // Reduce group winners; the lower group keeps ties.
    always_comb begin
        fv = 1'b0;
        fi = '0;
        fl = '1;
        for (int g = 0; g < NGRP; g++) begin
            if (s1_v[g] && (!fv || s1_l[g] < fl)) begin
                fv = 1'b1;
                fi = ID_W'(g * GROUP) + ID_W'(s1_i[g]);
                fl = s1_l[g];
            end
        end
    end

    // Stage-two register presenting the final winner.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            win_valid <= 1'b0;
            win_id    <= '0;
            win_lvl   <= '0;
        end else begin
            win_valid <= fv;
            win_id    <= fi;
            win_lvl   <= fl;
        end
    end

    a_r4_id_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        win_valid |-> (int'(win_id) < NUM_IRQ));
endmodule

// File: rtl/nic_nest.sv
// Service stack of levels, preemption test, acceptance and tail-chain decision.
// Assumes DEPTH >= 2 and that LAT matches the resolver's pipeline depth.
module nic_nest #(
    parameter int LVL_W = 6,
    parameter int ID_W  = 7,
    parameter int DEPTH = 8,
    parameter int LAT   = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             win_valid,
    input  logic [ID_W-1:0]  win_id,
    input  logic [LVL_W-1:0] win_lvl,
    input  logic             core_ack,
    input  logic             core_done,
    input  logic             flush,
    output logic             irq_req,
    output logic             tail_take,
    output logic             acc_valid,
    output logic [ID_W-1:0]  acc_id,
    output logic             run_valid,
    output logic [LVL_W-1:0] run_lvl
);
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam int BL_W  = $clog2(LAT + 1);

    logic [LVL_W-1:0] stk [DEPTH];
    logic [CNT_W-1:0] cnt;
    logic [BL_W-1:0]  blank;
    logic             live, full, below_ok, take_ack, pop;

    // Decide preemption, chaining and popping from the settled winner.
    always_comb begin
        live      = win_valid && (blank == '0);
        full      = (cnt == CNT_W'(DEPTH));
        irq_req   = live && !full && ((cnt == '0) || (win_lvl < stk[0]));
        below_ok  = (cnt <= CNT_W'(1)) || (win_lvl < stk[1]);
        tail_take = core_done && (cnt != '0) && live && below_ok;
        take_ack  = core_ack && irq_req && !core_done;
        pop       = core_done && (cnt != '0) && !tail_take;
        acc_valid = take_ack || tail_take;
        acc_id    = win_id;
        run_valid = (cnt != '0);
        run_lvl   = stk[0];
    end

    // Update the service stack: push on accept, replace on chain, shift on pop.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
            for (int k = 0; k < DEPTH; k++) stk[k] <= '0;
        end else if (take_ack) begin
            cnt    <= cnt + CNT_W'(1);
            stk[0] <= win_lvl;
            for (int k = 1; k < DEPTH; k++) stk[k] <= stk[k-1];
        end else if (tail_take) begin
            stk[0] <= win_lvl;
        end else if (pop) begin
            cnt <= cnt - CNT_W'(1);
            for (int k = 0; k < DEPTH - 1; k++) stk[k] <= stk[k+1];
            stk[DEPTH-1] <= '0;
        end
    end

    // Blank the winner while the pipeline still reflects pre-update state.
    always_ff @(posedge clk) begin
        if (!rst_n)                  blank <= '0;
        else if (acc_valid || flush) blank <= BL_W'(LAT);
        else if (blank != '0)        blank <= blank - BL_W'(1);
    end

    a_r7_push_level: assert property (@(posedge clk) disable iff (!rst_n)
        take_ack |=> (run_valid && run_lvl == $past(win_lvl)));

    a_r5_blank_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid |=> (!irq_req && !tail_take));

    a_r8_last_pop_empties: assert property (@(posedge clk) disable iff (!rst_n)
        (core_done && !tail_take && cnt == CNT_W'(1)) |=> !run_valid);

    a_r9_chain_keeps_depth: assert property (@(posedge clk) disable iff (!rst_n)
        tail_take |=> (cnt == $past(cnt)));

    a_r10_depth_bound: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CNT_W'(DEPTH));

    a_r11_idle_done_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (core_done && cnt == '0) |=> (cnt == '0));
endmodule

// File: rtl/nested_irq_ctrl.sv
// Top level: register file, pipelined resolver and nesting stack.
// Assumes the core pulses core_ack only on irq_req and core_done per handler exit.
module nested_irq_ctrl #(
    parameter int NUM_IRQ = 112,
    parameter int LVL_W   = 6,
    parameter int PRIO_W  = 8,
    parameter int DATA_W  = 32,
    parameter int ADDR_W  = 8,
    parameter int GROUP   = 16,
    parameter int DEPTH   = 8
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [NUM_IRQ-1:0]          irq_line,
    input  logic                        reg_we,
    input  logic [ADDR_W-1:0]           reg_addr,
    input  logic [DATA_W-1:0]           reg_wdata,
    output logic [DATA_W-1:0]           reg_rdata,
    input  logic                        core_ack,
    input  logic                        core_done,
    output logic                        irq_req,
    output logic [$clog2(NUM_IRQ)-1:0]  irq_id,
    output logic [LVL_W-1:0]            irq_prio,
    output logic                        tail_take,
    output logic                        run_valid,
    output logic [LVL_W-1:0]            run_prio
);
    localparam int ID_W = $clog2(NUM_IRQ);
    localparam int LAT  = 2;

    logic [NUM_IRQ-1:0]       req_vec;
    logic [NUM_IRQ*LVL_W-1:0] lvl_flat;
    logic                     win_valid, acc_valid;
    logic [ID_W-1:0]          win_id, acc_id;
    logic [LVL_W-1:0]         win_lvl;

    nic_regs #(
        .NUM_IRQ(NUM_IRQ), .LVL_W(LVL_W), .PRIO_W(PRIO_W),
        .DATA_W(DATA_W), .ADDR_W(ADDR_W), .ID_W(ID_W)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .irq_line(irq_line),
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .acc_valid(acc_valid), .acc_id(acc_id),
        .req_vec(req_vec), .lvl_flat(lvl_flat)
    );

    nic_resolver #(
        .NUM_IRQ(NUM_IRQ), .LVL_W(LVL_W), .GROUP(GROUP), .ID_W(ID_W)
    ) u_resolver (
        .clk(clk), .rst_n(rst_n), .req_vec(req_vec), .lvl_flat(lvl_flat),
        .win_valid(win_valid), .win_id(win_id), .win_lvl(win_lvl)
    );

    nic_nest #(
        .LVL_W(LVL_W), .ID_W(ID_W), .DEPTH(DEPTH), .LAT(LAT)
    ) u_nest (
        .clk(clk), .rst_n(rst_n), .win_valid(win_valid), .win_id(win_id),
        .win_lvl(win_lvl), .core_ack(core_ack), .core_done(core_done),
        .flush(reg_we), .irq_req(irq_req), .tail_take(tail_take),
        .acc_valid(acc_valid), .acc_id(acc_id),
        .run_valid(run_valid), .run_lvl(run_prio)
    );

    assign irq_id   = win_id;
    assign irq_prio = win_lvl;
endmodule

// File: tb/nested_irq_ctrl_bench.sv
// Directed bench: one task per scenario, each checking its own results.
module nested_irq_ctrl_bench;
    localparam int N = 112;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [N-1:0]  irq_line = '0;
    logic          reg_we = 1'b0;
    logic [7:0]    reg_addr = '0;
    logic [31:0]   reg_wdata = '0;
    logic [31:0]   reg_rdata;
    logic          core_ack = 1'b0, core_done = 1'b0;
    logic          irq_req, tail_take, run_valid;
    logic [6:0]    irq_id;
    logic [5:0]    irq_prio, run_prio;

    int n_tests = 0;
    int n_fail  = 0;

    always #10 clk = ~clk;

    nested_irq_ctrl u_nested_irq_ctrl (
        .clk(clk), .rst_n(rst_n), .irq_line(irq_line),
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .core_ack(core_ack), .core_done(core_done),
        .irq_req(irq_req), .irq_id(irq_id), .irq_prio(irq_prio),
        .tail_take(tail_take), .run_valid(run_valid), .run_prio(run_prio)
    );

    function automatic logic [7:0] ad(input int region, input int idx);
        return {region[2:0], idx[4:0]};
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        #1;
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; irq_line = '0; reg_we = 1'b0; core_ack = 1'b0; core_done = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic settle();
        repeat (3) @(negedge clk);
    endtask

    task automatic set_lvl(input int line, input int lvl);
        wr(ad(3, line / 4), (32'(lvl) << 2) << (8 * (line % 4)));
    endtask

    task automatic pend(input int line);
        wr(ad(1, line / 32), 32'd1 << (line % 32));
    endtask

    task automatic enable_all();
        for (int w = 0; w < 4; w++) wr(ad(0, w), 32'hFFFF_FFFF);
    endtask

    task automatic ack();
        core_ack = 1'b1;
        @(negedge clk);
        core_ack = 1'b0;
    endtask

    task automatic done(output logic tk);
        core_done = 1'b1;
        #1;
        tk = tail_take;
        @(negedge clk);
        core_done = 1'b0;
    endtask

    task automatic t_reset();
        logic [31:0] d;
        do_reset();
        wr(ad(0, 0), 32'hFFFF_FFFF);
        wr(ad(1, 0), 32'h0000_00F0);
        wr(ad(3, 0), 32'hFFFF_FFFF);
        do_reset();
        rd(ad(0, 0), d); chk("R1 enable after reset", d, 0);
        rd(ad(1, 0), d); chk("R1 pending after reset", d, 0);
        rd(ad(3, 0), d); chk("R1 priority after reset", d, 0);
        chk("R1 irq_req after reset", 32'(irq_req), 0);
        chk("R1 run_valid after reset", 32'(run_valid), 0);
        chk("R1 tail_take after reset", 32'(tail_take), 0);
    endtask

    task automatic t_prio_field();
        logic [31:0] d;
        do_reset();
        wr(ad(3, 0), 32'hFFFF_FFFF);
        rd(ad(3, 0), d); chk("R3 low bits read zero", d, 32'hFCFC_FCFC);
        wr(ad(3, 27), 32'h1234_5678);
        rd(ad(3, 27), d); chk("R3 last word readback", d, 32'h1034_5478);
    endtask

    task automatic t_pending();
        logic [31:0] d;
        do_reset();
        pend(35);
        rd(ad(1, 1), d); chk("R2 set region", d, 32'h8);
        rd(ad(2, 1), d); chk("R2 clear region reads pending", d, 32'h8);
        wr(ad(1, 1), 32'h0);
        rd(ad(1, 1), d); chk("R2 writing zero to set", d, 32'h8);
        wr(ad(2, 1), 32'h0);
        rd(ad(1, 1), d); chk("R2 writing zero to clear", d, 32'h8);
        wr(ad(2, 1), 32'h8);
        rd(ad(1, 1), d); chk("R2 clear", d, 32'h0);
        irq_line[5] = 1'b1; irq_line[111] = 1'b1;
        @(negedge clk);
        irq_line = '0;
        @(negedge clk);
        rd(ad(1, 0), d); chk("R2 line sticky low word", d, 32'h20);
        rd(ad(1, 3), d); chk("R2 line sticky top line", d, 32'h8000);
    endtask

    task automatic t_select();
        do_reset();
        set_lvl(20, 16);
        wr(ad(3, 12), 32'h23 << 16);  // line 50, raw 0x23 -> level 8
        wr(ad(3, 7), 32'h20 << 16);   // line 30, level 8
        wr(ad(3, 15), 32'h20);        // line 60, level 8
        pend(50);
        settle();
        chk("R4 disabled pending not presented", 32'(irq_req), 0);
        wr(ad(2, 1), 32'hFFFF_FFFF);
        enable_all();
        settle();
        irq_line[20] = 1'b1;
        @(negedge clk);
        irq_line = '0;
        chk("R5 one edge after line", 32'(irq_req), 0);
        @(negedge clk);
        chk("R5 two edges after line", 32'(irq_req), 0);
        @(negedge clk);
        chk("R5 three edges after line", 32'(irq_req), 1);
        chk("R4 single winner id", 32'(irq_id), 20);
        chk("R4 single winner level", 32'(irq_prio), 16);
        pend(50);
        settle();
        chk("R4 lower value wins id", 32'(irq_id), 50);
        chk("R3 level ignores low bits", 32'(irq_prio), 8);
        wr(ad(0, 1), 32'h0);
        chk("R5 blank after write", 32'(irq_req), 0);
        @(negedge clk);
        chk("R5 blank second cycle", 32'(irq_req), 0);
        @(negedge clk);
        chk("R5 valid after blank", 32'(irq_req), 1);
        chk("R4 disabled line skipped", 32'(irq_id), 20);
        wr(ad(0, 1), 32'hFFFF_FFFF);
        pend(60);
        settle();
        chk("R4 tie keeps lower id", 32'(irq_id), 50);
        pend(30);
        settle();
        chk("R4 tie goes to lower id", 32'(irq_id), 30);
        wr(ad(2, 0), 32'd1 << 30);
        settle();
        chk("R2 cleared line leaves race", 32'(irq_id), 50);
    endtask

    task automatic t_nest();
        logic [31:0] d;
        logic tk;
        do_reset();
        set_lvl(20, 16);
        wr(ad(3, 7), 32'h20 << 16);   // line 30, level 8
        wr(ad(3, 12), 32'h20 << 16);  // line 50, level 8
        enable_all();
        pend(20);
        settle();
        chk("R6 idle preempt", 32'(irq_req), 1);
        ack();
        chk("R7 run level after accept", 32'(run_prio), 16);
        chk("R7 run_valid after accept", 32'(run_valid), 1);
        rd(ad(1, 0), d); chk("R7 pending cleared on accept", d, 0);
        pend(20);
        rd(ad(1, 0), d); chk("R7 re-pend while active", d, 32'h0010_0000);
        settle();
        chk("R6 equal level no preempt", 32'(irq_req), 0);
        pend(50);
        settle();
        chk("R6 higher level preempts", 32'(irq_req), 1);
        chk("R6 preempting id", 32'(irq_id), 50);
        ack();
        chk("R7 nested level", 32'(run_prio), 8);
        pend(30);
        settle();
        chk("R6 equal nested no preempt", 32'(irq_req), 0);
        done(tk);
        chk("R9 chain on exit", 32'(tk), 1);
        chk("R9 chained level", 32'(run_prio), 8);
        rd(ad(1, 0), d); chk("R9 chained pending cleared", d, 32'h0010_0000);
        settle();
        done(tk);
        chk("R9 no chain when not above below", 32'(tk), 0);
        chk("R8 pop restores level", 32'(run_prio), 16);
        chk("R8 pop keeps valid", 32'(run_valid), 1);
        settle();
        chk("R6 equal after pop", 32'(irq_req), 0);
        done(tk);
        chk("R9 chain at single level", 32'(tk), 1);
        chk("R9 single chain stays active", 32'(run_valid), 1);
        rd(ad(1, 0), d); chk("R9 pending cleared at base chain", d, 0);
        settle();
        done(tk);
        chk("R8 last pop empties", 32'(run_valid), 0);
        chk("R8 no chain with nothing pending", 32'(tk), 0);
    endtask

    task automatic t_full();
        logic tk;
        logic [31:0] w0, w1;
        int ok;
        do_reset();
        w0 = '0; w1 = '0;
        for (int i = 0; i < 4; i++) w0 |= (32'(30 - i) << 2) << (8 * i);
        for (int i = 4; i < 8; i++) w1 |= (32'(30 - i) << 2) << (8 * (i - 4));
        wr(ad(3, 0), w0);
        wr(ad(3, 1), w1);
        wr(ad(3, 2), 32'(10) << 2);
        wr(ad(0, 0), 32'h1FF);
        ok = 1;
        for (int i = 0; i < 8; i++) begin
            pend(i);
            settle();
            if (!(irq_req === 1'b1 && irq_id == 7'(i))) ok = 0;
            ack();
        end
        chk("R7 eight nested accepts", 32'(ok), 1);
        chk("R7 top level after eight", 32'(run_prio), 23);
        pend(8);
        settle();
        chk("R10 full stack blocks preempt", 32'(irq_req), 0);
        done(tk);
        chk("R10 chain still allowed when full", 32'(tk), 1);
        chk("R10 chained level", 32'(run_prio), 10);
    endtask

    task automatic t_ignore();
        logic tk;
        do_reset();
        enable_all();
        settle();
        ack();
        chk("R11 ack without request", 32'(run_valid), 0);
        pend(3);
        settle();
        done(tk);
        chk("R11 done when idle no chain", 32'(tk), 0);
        chk("R11 done when idle stays idle", 32'(run_valid), 0);
        chk("R11 request kept after idle done", 32'(irq_req), 1);
        ack();
        chk("R7 accept after idle done", 32'(run_valid), 1);
    endtask

    initial begin
        #(20 * 150000);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        t_reset();
        t_prio_field();
        t_pending();
        t_select();
        t_nest();
        t_full();
        t_ignore();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule